// File: doc/BRIEF.md
# Fractional hundredths-of-second divider

This block turns a 4096 Hz enable strobe into a 100 Hz strobe. 4096 is not a multiple of 100, so no single integer divisor works. The block instead switches between two divisors in a fixed pattern. Within a frame of 25 output periods, the first 24 periods each last 41 input ticks and the last period lasts 40 ticks. That gives 1024 ticks per frame, or 250 ms. Any single period may be off by a fraction of a tick, but the average ratio is exactly 40.96, so the long-term rate is exactly 100 Hz and the phase lines up again at every frame boundary.

Each 100 Hz strobe advances a two-digit BCD hundredths value. When that value steps from 99 to 00, the block raises a one-cycle carry that feeds a seconds counter downstream. A write port lets software set the hundredths value. A write also restarts both the divider and the frame position, so the next strobe comes a full long period after the write.

Top module: `hund_divider`

## Requirements
- R1: While rst_ni is low, hund_o reads 8'h00 and tick100_o and sec_carry_o are low. After release, the first strobe follows the 41st accepted tick.
- R2: tick100_o is high for exactly one clock cycle, in the cycle right after the clock edge that accepted the tick that completes a period.
- R3: Counting from a restart, periods 1 to 24 of each 25-period frame take 41 accepted ticks and period 25 takes 40. One frame takes 1024 ticks.
- R4: hund_o holds two BCD digits: tens in [7:4] and units in [3:0]. Each digit stays in 0..9, and the value goes up by one, 00 through 99, at every strobe.
- R5: sec_carry_o is high for one cycle, in the same cycle as the strobe that moves hund_o from 99 to 00, and at no other time.
- R6: When wr_en_i is high at a clock edge, hund_o takes wr_data_i and the divider and frame position restart, so the next strobe comes 41 ticks later. A tick presented in the same cycle as the write is ignored and produces no strobe.
- R7: tick100_o rises only in the cycle after tick_i was high. Cycles with tick_i low change neither the outputs nor the divider state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 4096 Hz single-cycle enable strobe |
| wr_en_i | input | 1 | Loads the hundredths value and restarts the divider |
| wr_data_i | input | 8 | BCD hundredths value to load |
| tick100_o | output | 1 | 100 Hz single-cycle strobe |
| hund_o | output | 8 | BCD hundredths value |
| sec_carry_o | output | 1 | One-cycle carry into the seconds counter |

## Verification
The short 40-tick period only occurs as the 25th period after a restart, and the frame position cannot be seen at the ports. The bench therefore writes first, which puts the frame in a known position. It then measures the length of each of the next 25 periods in ticks and checks their sum. The 99-to-00 carry is reached both by loading 99 directly and by running 100 periods from 00. A write that arrives together with a tick is applied in the same cycle, to show that the tick is dropped.

// File: rtl/hund_pkg.sv
package hund_pkg;
  typedef struct packed {
    logic [3:0] tens;
    logic [3:0] units;
  } bcd2_t;
endpackage

// File: rtl/frac_div.sv
module frac_div #(
  parameter int DIV_HI  = 41,
  parameter int DIV_LO  = 40,
  parameter int HI_RUNS = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  output logic wrap_o
);
  localparam int FRAME_LEN = HI_RUNS + 1;
  localparam int CW = $clog2(DIV_HI);
  localparam int FW = $clog2(FRAME_LEN);

  logic [CW-1:0] cnt_q;
  logic [FW-1:0] frame_q;
  logic          last_run;
  logic [CW-1:0] term;

  assign last_run = (frame_q == FW'(HI_RUNS));
  assign term     = last_run ? CW'(DIV_LO - 1) : CW'(DIV_HI - 1);
  assign wrap_o   = tick_i && !clear_i && (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      frame_q <= '0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      frame_q <= '0;
    end else if (tick_i) begin
      if (wrap_o) begin
        cnt_q   <= '0;
        frame_q <= last_run ? '0 : frame_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcd_hund.sv
module bcd_hund
  import hund_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  inc_i,
  input  logic  load_i,
  input  bcd2_t load_val_i,
  output bcd2_t val_o,
  output logic  carry_o
);
  bcd2_t val_q;
  bcd2_t val_nx;
  logic  units_wrap, tens_wrap;

  assign units_wrap = (val_q.units == 4'd9);
  assign tens_wrap  = (val_q.tens == 4'd9);

  always_comb begin
    val_nx.units = units_wrap ? 4'd0 : val_q.units + 4'd1;
    val_nx.tens  = val_q.tens;
    if (units_wrap) val_nx.tens = tens_wrap ? 4'd0 : val_q.tens + 4'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q   <= '0;
      carry_o <= 1'b0;
    end else if (load_i) begin
      val_q   <= load_val_i;
      carry_o <= 1'b0;
    end else begin
      carry_o <= inc_i && units_wrap && tens_wrap;
      if (inc_i) val_q <= val_nx;
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/hund_divider.sv
module hund_divider
  import hund_pkg::*;
#(
  parameter int DIV_HI  = 41,
  parameter int DIV_LO  = 40,
  parameter int HI_RUNS = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic       tick100_o,
  output logic [7:0] hund_o,
  output logic       sec_carry_o
);
  logic  wrap;
  bcd2_t hund_val;

  frac_div #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO), .HI_RUNS(HI_RUNS)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clear_i(wr_en_i),
    .wrap_o (wrap)
  );

  bcd_hund u_bcd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (wrap),
    .load_i    (wr_en_i),
    .load_val_i(bcd2_t'(wr_data_i)),
    .val_o     (hund_val),
    .carry_o   (sec_carry_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick100_o <= 1'b0;
    else         tick100_o <= wrap;
  end

  assign hund_o = hund_val;
endmodule

// File: rtl/hund_divider_chk.sv
module hund_divider_chk #(
  parameter int DIV_HI = 41,
  parameter int DIV_LO = 40
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       tick100_o,
  input logic [7:0] hund_o,
  input logic       sec_carry_o
);
  logic [7:0] seen_q;

  // Ticks accepted since the last strobe or write, including the one that completes a period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= '0;
    else if (wr_en_i)   seen_q <= '0;
    else if (tick100_o) seen_q <= tick_i ? 8'd1 : 8'd0;
    else if (tick_i)    seen_q <= seen_q + 8'd1;
  end

  assert_single_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick100_o |=> !tick100_o);
  assert_period_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick100_o |-> (seen_q == 8'(DIV_HI) || seen_q == 8'(DIV_LO)));
  assert_bcd_digits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hund_o[7:4] <= 4'd9) && (hund_o[3:0] <= 4'd9));
  assert_carry_rollover_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_carry_o |-> (tick100_o && hund_o == 8'h00));
  assert_write_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (!tick100_o && hund_o == $past(wr_data_i)));
  assert_strobe_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tick100_o) |-> $past(tick_i));
endmodule

bind hund_divider hund_divider_chk #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .tick100_o  (tick100_o),
  .hund_o     (hund_o),
  .sec_carry_o(sec_carry_o)
);

// File: tb/hund_divider_test.sv
`timescale 1ns/1ps
module hund_divider_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       tick100_o;
  logic [7:0] hund_o;
  logic       sec_carry_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  hund_divider uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .tick100_o(tick100_o), .hund_o(hund_o),
    .sec_carry_o(sec_carry_o)
  );

  // {load value, expected value after one period, expected carry}
  localparam logic [16:0] VEC [0:5] = '{
    {8'h00, 8'h01, 1'b0},
    {8'h09, 8'h10, 1'b0},
    {8'h59, 8'h60, 1'b0},
    {8'h98, 8'h99, 1'b0},
    {8'h99, 8'h00, 1'b1},
    {8'h47, 8'h48, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v, input logic with_tick);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = v; tick_i = with_tick;
    @(negedge clk_i);
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  // Give ticks with one idle cycle between them until a strobe shows up
  task automatic measure(output int n, output logic cy, output logic [7:0] h);
    n = 0; cy = 1'b0; h = 8'h00;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i); tick_i = 1'b1; n++;
      @(negedge clk_i); tick_i = 1'b0;
      if (tick100_o) begin
        cy = sec_carry_o; h = hund_o;
        @(negedge clk_i);
        chk(!tick100_o, "R2 strobe width", int'(tick100_o), 0);
        return;
      end else if (sec_carry_o) begin
        chk(1'b0, "R5 carry without strobe", 1, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int total;
    int carries;
    logic cy;
    logic [7:0] h;

    repeat (3) @(negedge clk_i);
    chk(hund_o == 8'h00 && !tick100_o && !sec_carry_o, "R1 reset state", hund_o, 0);
    rst_ni = 1'b1;

    // R1: first period after release
    measure(n, cy, h);
    chk(n == 41, "R1 first period", n, 41);
    chk(h == 8'h01, "R4 first increment", h, 8'h01);

    // Vector table: write, one period, check value and carry (R4 R5 R6)
    foreach (VEC[k]) begin
      do_write(VEC[k][16:9], 1'b0);
      chk(hund_o == VEC[k][16:9] && !tick100_o, "R6 load", hund_o, VEC[k][16:9]);
      measure(n, cy, h);
      chk(n == 41, "R6 restart period", n, 41);
      chk(h == VEC[k][8:1], "R4 bcd step", h, VEC[k][8:1]);
      chk(cy == VEC[k][0], "R5 carry", cy, VEC[k][0]);
    end

    // R3: one frame after restart
    do_write(8'h00, 1'b0);
    total = 0;
    for (int p = 0; p < 25; p++) begin
      measure(n, cy, h);
      total += n;
      chk(n == ((p < 24) ? 41 : 40), "R3 period length", n, (p < 24) ? 41 : 40);
    end
    chk(total == 1024, "R3 frame length", total, 1024);
    chk(h == 8'h25, "R4 after frame", h, 8'h25);

    // R5: run from 25 through rollover and back to 25
    carries = 0;
    for (int p = 0; p < 100; p++) begin
      measure(n, cy, h);
      if (cy) begin
        carries++;
        chk(h == 8'h00, "R5 carry value", h, 0);
      end
    end
    chk(carries == 1, "R5 carry count", carries, 1);
    chk(h == 8'h25, "R4 full cycle", h, 8'h25);

    // R7: idle cycles change nothing
    h = hund_o;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      chk(!tick100_o && hund_o == h, "R7 idle hold", hund_o, h);
    end
    // R7: 40 of 41 ticks, idle gap, one more tick completes the period
    do_write(8'h10, 1'b0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
    repeat (5) @(negedge clk_i);
    chk(!tick100_o && hund_o == 8'h10, "R7 no early strobe", hund_o, 8'h10);
    measure(n, cy, h);
    chk(n == 1 && h == 8'h11, "R7 state kept over gap", n, 1);

    // R6: write together with a tick, the tick is dropped
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
    do_write(8'h33, 1'b1);
    chk(!tick100_o && hund_o == 8'h33, "R6 write beats tick", hund_o, 8'h33);
    measure(n, cy, h);
    chk(n == 41 && h == 8'h34, "R6 restart after tick collision", n, 41);

    // R1: reset in the middle of a period
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(hund_o == 8'h00 && !tick100_o && !sec_carry_o, "R1 mid reset", hund_o, 0);
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
    chk(!tick100_o && hund_o == 8'h00, "R1 tick during reset", hund_o, 0);
    rst_ni = 1'b1;
    measure(n, cy, h);
    chk(n == 41 && h == 8'h01, "R1 restart after reset", n, 41);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule